// File: doc/BRIEF.md
# Private L1 Line Coherence Controller (MOESI, directory based)

This block holds the coherence state of one line of a private first-level cache in a system where a directory keeps track of sharers. Each cycle it sees at most one core operation (load, store, eviction, DMA flush) and at most one incoming coherence message (fill data, acknowledgement, invalidation, forwarded shared or exclusive read). It answers the core with a hit or a stall, sends outgoing requests to the directory, sends ack or data replies, and shows the access permission of the line. Data storage, tag matching and the network are outside the block.

Beyond the usual five MOESI states the controller has two write-protected states, a clean one (EXC_LK) and a dirty one (DRT_LK). A line entering either one is held for a programmable number of cycles. During that time evictions and DMA flushes are refused, while loads and stores are still served. When the hold time runs out, the line drops back to plain clean-exclusive (EXC) or dirty-exclusive (DRT). A store to EXC_LK upgrades silently to DRT_LK. A store that lacks write permission sends GETX and then waits for the fill data and for the directory's count of acknowledgements. Acknowledgements that arrive before the data are counted as well.

Top module: `l1_coh_line`

## Requirements
- R1: After a synchronous active-low reset the line is in state INV. The line_state encoding is INV=0, SHR=1, OWN=2, EXC=3, EXC_LK=4, DRT=5, DRT_LK=6, FILL_S=7, FILL_X=8, UPG=9, ACKW=10. line_perm reads 0 (none), and the outputs core_hit, core_stall, req_kind, rsp_ack and rsp_data are all 0.
- R2: A load in INV stalls, issues GETS (req_kind=1) and enters FILL_S, where further loads stall without a new request. A fill (msg_kind=0) with msg_grant 0 (shared) goes to SHR, with grant 1 (exclusive) goes to EXC_LK, and with grant 2 (owned) goes to OWN. A load hits in every state that holds data.
- R3: A store in INV stalls, issues GETX (req_kind=2) and enters FILL_X. A store in SHR, EXC or OWN stalls, issues GETX and enters UPG.
- R4: A store in EXC_LK hits, issues no request and moves to DRT_LK. A store in DRT or DRT_LK hits with no state change. line_perm is 1 in FILL_S and FILL_X, 2 in SHR, OWN, EXC, EXC_LK, UPG and ACKW, and 3 in DRT and DRT_LK.
- R5: In EXC_LK and DRT_LK an eviction or DMA request stalls, issues nothing and leaves the state unchanged.
- R6: A line stays in EXC_LK or DRT_LK for exactly LOCK_CYCLES cycles after it enters that state, then falls to EXC or DRT. The silent upgrade of R4 restarts the count.
- R7: In FILL_X or UPG, a fill carries in msg_acks the number of acknowledgements still to arrive. Each ACK (msg_kind=1) takes one away, and ACKs received before the fill are counted too. Once the fill is in and the count is zero, the line enters DRT_LK. Until then it waits in ACKW.
- R8: In UPG and ACKW loads hit, while stores, evictions and DMA requests stall with no request.
- R9: An eviction or DMA request in DRT or EXC issues PUTX (3) and goes to INV. In OWN it issues PUTO (4), or PUTO with sharers (5) if the line has handed out a shared copy since it became owner, and goes to INV. In SHR it goes to INV silently. In INV it has no effect.
- R10: An invalidation (msg_kind=2) always pulses rsp_ack. It sends SHR, OWN, EXC, DRT and the two locked states to INV, and sends UPG to FILL_X.
- R11: A forwarded shared read (msg_kind=3) in OWN, EXC, DRT or a locked state pulses rsp_data and leaves the line in OWN. A forwarded exclusive read (msg_kind=4) in those states pulses rsp_data and leaves the line in INV.
- R12: When a message and a core request arrive in the same cycle, the message is handled and the core request stalls. When a store arrives in EXC_LK in the very cycle the hold time expires, the upgrade wins and the line ends in DRT_LK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ld | input | 1 | Core load request |
| core_st | input | 1 | Core store request |
| core_evict | input | 1 | Replacement request for the line |
| core_dma | input | 1 | DMA flush request for the line |
| msg_valid | input | 1 | Incoming coherence message present |
| msg_kind | input | 3 | 0 fill, 1 ack, 2 invalidate, 3 fwd shared read, 4 fwd exclusive read |
| msg_grant | input | 2 | Fill grant: 0 shared, 1 exclusive, 2 owned |
| msg_acks | input | ACK_W | Acknowledgements still due, carried by a fill |
| core_hit | output | 1 | Core request served this cycle |
| core_stall | output | 1 | Core request must be retried |
| req_kind | output | 3 | 0 none, 1 GETS, 2 GETX, 3 PUTX, 4 PUTO, 5 PUTO with sharers |
| rsp_ack | output | 1 | Acknowledgement reply |
| rsp_data | output | 1 | Data reply to a forwarded read |
| line_perm | output | 2 | 0 none, 1 busy, 2 read-only, 3 read-write |
| line_state | output | 4 | Current state code (R1) |

## Verification
Two pairs of events can land in the same cycle. The first pair is the expiry of the hold timer and a store in EXC_LK. The bench places the store in the last cycle of the hold window and expects DRT_LK afterwards, with a hit and no request. The second pair is an incoming invalidation and a core load. The bench drives both together in DRT_LK and expects an ack, a stalled load with no hit, and INV afterwards. The ack counter is also exercised with acknowledgements that arrive both before and after the fill.

// File: rtl/l1c_pkg.sv
// Package: shared state, request and message encodings for the L1 line
// coherence controller. Assumes one message and one core operation per cycle.
package l1c_pkg;

    typedef enum logic [3:0] {
        ST_INV    = 4'd0,
        ST_SHR    = 4'd1,
        ST_OWN    = 4'd2,
        ST_EXC    = 4'd3,
        ST_EXC_LK = 4'd4,
        ST_DRT    = 4'd5,
        ST_DRT_LK = 4'd6,
        ST_FILL_S = 4'd7,
        ST_FILL_X = 4'd8,
        ST_UPG    = 4'd9,
        ST_ACKW   = 4'd10
    } lstate_e;

    typedef enum logic [2:0] {
        RQ_NONE    = 3'd0,
        RQ_GETS    = 3'd1,
        RQ_GETX    = 3'd2,
        RQ_PUTX    = 3'd3,
        RQ_PUTO    = 3'd4,
        RQ_PUTO_SH = 3'd5
    } req_e;

    localparam logic [2:0] MK_FILL     = 3'd0;
    localparam logic [2:0] MK_ACK      = 3'd1;
    localparam logic [2:0] MK_INVAL    = 3'd2;
    localparam logic [2:0] MK_FWD_SHR  = 3'd3;
    localparam logic [2:0] MK_FWD_EXCL = 3'd4;

    localparam logic [1:0] GR_SHARED = 2'd0;
    localparam logic [1:0] GR_EXCL   = 2'd1;
    localparam logic [1:0] GR_OWNED  = 2'd2;

    localparam logic [1:0] PM_NONE = 2'd0;
    localparam logic [1:0] PM_BUSY = 2'd1;
    localparam logic [1:0] PM_RO   = 2'd2;
    localparam logic [1:0] PM_RW   = 2'd3;

    // Access permission implied by a state.
    function automatic logic [1:0] perm_of(lstate_e s);
        case (s)
            ST_INV:                 return PM_NONE;
            ST_FILL_S, ST_FILL_X:   return PM_BUSY;
            ST_DRT, ST_DRT_LK:      return PM_RW;
            default:                return PM_RO;
        endcase
    endfunction

    // True for the two write-protected states.
    function automatic logic is_locked(lstate_e s);
        return (s == ST_EXC_LK) || (s == ST_DRT_LK);
    endfunction

endpackage

// File: rtl/l1c_lock_timer.sv
// Hold timer for the write-protected states. A start pulse loads the count.
// While run stays high the count goes down, and expire is raised in the
// LOCK_CYCLES-th cycle after start. Assumes LOCK_CYCLES >= 1.
module l1c_lock_timer #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Load on start, count down while running, disarm once the line leaves the locked state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            cnt_q   <= LOAD;
        end else if (!run) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = armed_q && (cnt_q == '0);

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && run && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("lock timer skipped a step");

    p_start_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (armed_q && cnt_q == LOAD))
        else $error("lock timer not reloaded");

endmodule

// File: rtl/l1c_ack_track.sv
// Acknowledgement tracker for an outstanding exclusive request. It keeps a
// signed balance of acks still due: a fill adds its count, each ack takes
// one away, and the balance saturates at both ends. done is raised in the
// cycle of the event that leaves the fill received and the balance at zero.
module l1c_ack_track #(
    parameter int ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             data_ev,
    input  logic             ack_ev,
    input  logic [ACK_W-1:0] acks_in,
    output logic             done
);
    localparam int PW = ACK_W + 2;
    localparam logic signed [PW:0] S_MAX = (PW+1)'((1 << ACK_W) - 1);
    localparam logic signed [PW:0] S_MIN = -((PW+1)'(1 << ACK_W));

    logic signed [PW-1:0] pend_q, pend_nx;
    logic signed [PW:0]   sum;
    logic                 hd_q, hd_nx;

    // Next balance and fill flag, with saturation.
    always_comb begin
        pend_nx = pend_q;
        hd_nx   = hd_q;
        sum     = '0;
        if (clear) begin
            pend_nx = '0;
            hd_nx   = 1'b0;
        end else if (data_ev) begin
            sum     = {pend_q[PW-1], pend_q} + $signed({3'b000, acks_in});
            pend_nx = (sum > S_MAX) ? S_MAX[PW-1:0] : sum[PW-1:0];
            hd_nx   = 1'b1;
        end else if (ack_ev) begin
            sum     = {pend_q[PW-1], pend_q} - (PW+1)'(1);
            pend_nx = (sum < S_MIN) ? S_MIN[PW-1:0] : sum[PW-1:0];
        end
    end

    // Register the balance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            hd_q   <= 1'b0;
        end else begin
            pend_q <= pend_nx;
            hd_q   <= hd_nx;
        end
    end

    assign done = (data_ev || ack_ev) && hd_nx && (pend_nx == '0);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear || data_ev || ack_ev) |=> ($stable(pend_q) && $stable(hd_q)))
        else $error("ack balance moved without an event");

    p_ack_decr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ev && !clear && !data_ev && pend_q > S_MIN[PW-1:0] + 1) |=> (pend_q == $past(pend_q) - 1))
        else $error("ack did not reduce balance");

endmodule

// File: rtl/l1_coh_line.sv
// Coherence state controller for one private L1 line in a directory-based
// MOESI system, with timed write-protected states. Assumes at most one core
// operation per cycle. When several are raised, the priority is store, then
// load, then eviction/DMA. An incoming message always takes precedence over
// the core, which is stalled in that cycle.
module l1_coh_line
    import l1c_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    parameter int ACK_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_ld,
    input  logic             core_st,
    input  logic             core_evict,
    input  logic             core_dma,
    input  logic             msg_valid,
    input  logic [2:0]       msg_kind,
    input  logic [1:0]       msg_grant,
    input  logic [ACK_W-1:0] msg_acks,
    output logic             core_hit,
    output logic             core_stall,
    output logic [2:0]       req_kind,
    output logic             rsp_ack,
    output logic             rsp_data,
    output logic [1:0]       line_perm,
    output logic [3:0]       line_state
);
    lstate_e state_q, state_nx;
    req_e    req;
    logic    sharers_q, sharers_nx;
    logic    gx_start, data_ev, ack_ev, trk_done, tmo_expire;
    logic    core_busy, holds_own;

    assign core_busy = core_ld || core_st || core_evict || core_dma;
    assign holds_own = (state_q == ST_OWN) || (state_q == ST_EXC) || (state_q == ST_DRT)
                    || is_locked(state_q);
    assign data_ev   = msg_valid && (msg_kind == MK_FILL)
                    && (state_q == ST_FILL_X || state_q == ST_UPG);
    assign ack_ev    = msg_valid && (msg_kind == MK_ACK)
                    && (state_q == ST_FILL_X || state_q == ST_UPG || state_q == ST_ACKW);

    l1c_ack_track #(.ACK_W(ACK_W)) u_acks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (gx_start),
        .data_ev (data_ev),
        .ack_ev  (ack_ev),
        .acks_in (msg_acks),
        .done    (trk_done)
    );

    l1c_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (is_locked(state_nx) && state_nx != state_q),
        .run    (is_locked(state_nx)),
        .expire (tmo_expire)
    );

    // Next state, core reply and outgoing traffic for the current cycle.
    always_comb begin
        state_nx   = state_q;
        sharers_nx = sharers_q;
        req        = RQ_NONE;
        core_hit   = 1'b0;
        core_stall = 1'b0;
        rsp_ack    = 1'b0;
        rsp_data   = 1'b0;
        gx_start   = 1'b0;
        if (msg_valid) begin
            core_stall = core_busy;
            case (msg_kind)
                MK_INVAL: begin
                    rsp_ack = 1'b1;
                    if (state_q == ST_UPG)                   state_nx = ST_FILL_X;
                    else if (holds_own || state_q == ST_SHR) state_nx = ST_INV;
                end
                MK_FWD_SHR: if (holds_own) begin
                    rsp_data   = 1'b1;
                    state_nx   = ST_OWN;
                    sharers_nx = 1'b1;
                end
                MK_FWD_EXCL: if (holds_own) begin
                    rsp_data = 1'b1;
                    state_nx = ST_INV;
                end
                MK_FILL: begin
                    if (state_q == ST_FILL_S) begin
                        case (msg_grant)
                            GR_EXCL:  state_nx = ST_EXC_LK;
                            GR_OWNED: begin
                                state_nx   = ST_OWN;
                                sharers_nx = 1'b0;
                            end
                            default:  state_nx = ST_SHR;
                        endcase
                    end else if (data_ev) begin
                        state_nx = trk_done ? ST_DRT_LK : ST_ACKW;
                    end
                end
                MK_ACK: if (state_q == ST_ACKW && trk_done) state_nx = ST_DRT_LK;
                default: ;
            endcase
        end else if (core_st) begin
            case (state_q)
                ST_DRT, ST_DRT_LK: core_hit = 1'b1;
                ST_EXC_LK: begin
                    core_hit = 1'b1;
                    state_nx = ST_DRT_LK;
                end
                ST_INV, ST_SHR, ST_EXC, ST_OWN: begin
                    core_stall = 1'b1;
                    req        = RQ_GETX;
                    gx_start   = 1'b1;
                    state_nx   = (state_q == ST_INV) ? ST_FILL_X : ST_UPG;
                end
                default: core_stall = 1'b1;
            endcase
        end else if (core_ld) begin
            case (state_q)
                ST_INV: begin
                    core_stall = 1'b1;
                    req        = RQ_GETS;
                    state_nx   = ST_FILL_S;
                end
                ST_FILL_S, ST_FILL_X: core_stall = 1'b1;
                default: core_hit = 1'b1;
            endcase
        end else if (core_evict || core_dma) begin
            case (state_q)
                ST_DRT, ST_EXC: begin
                    req      = RQ_PUTX;
                    state_nx = ST_INV;
                end
                ST_OWN: begin
                    req      = sharers_q ? RQ_PUTO_SH : RQ_PUTO;
                    state_nx = ST_INV;
                end
                ST_SHR:  state_nx = ST_INV;
                ST_INV:  ;
                default: core_stall = 1'b1;
            endcase
        end
        if (state_nx == state_q && tmo_expire) begin
            if (state_q == ST_EXC_LK)      state_nx = ST_EXC;
            else if (state_q == ST_DRT_LK) state_nx = ST_DRT;
        end
    end

    // State and sharer-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_INV;
            sharers_q <= 1'b0;
        end else begin
            state_q   <= state_nx;
            sharers_q <= sharers_nx;
        end
    end

    assign req_kind   = req;
    assign line_perm  = perm_of(state_q);
    assign line_state = state_q;

    p_silent_upgrade_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == ST_EXC_LK && core_st && !msg_valid)
            |-> (core_hit && req_kind == RQ_NONE) ##1 (line_state == ST_DRT_LK))
        else $error("silent upgrade broken");

    p_lock_refuses_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_locked(state_q) && (core_evict || core_dma) && !core_ld && !core_st && !msg_valid)
            |-> (core_stall && req_kind == RQ_NONE) ##1 $stable(line_state))
        else $error("eviction accepted while locked");

    p_timeout_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_locked(state_q) && tmo_expire && !msg_valid && !core_busy)
            |=> (line_state == ST_EXC || line_state == ST_DRT))
        else $error("lock did not fall on expiry");

    p_inval_acks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_INVAL) |-> rsp_ack)
        else $error("invalidation without ack");

    p_msg_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && core_busy) |-> (core_stall && !core_hit))
        else $error("core served while a message was handled");

    p_hit_or_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_hit && core_stall))
        else $error("hit and stall together");

endmodule

// File: tb/l1_coh_line_tb.sv
`timescale 1ns/1ps
module l1_coh_line_tb;
    localparam int LOCK = 5;
    localparam int AW   = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld = 0, st = 0, ev = 0, dm = 0, mv = 0;
    logic [2:0] mk = '0;
    logic [1:0] gr = '0;
    logic [AW-1:0] ac = '0;
    logic hit, stall, rack, rdat;
    logic [2:0] rq;
    logic [1:0] perm;
    logic [3:0] lst;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic c_hit, c_stall, c_ack, c_dat;
    logic [2:0] c_rq;
    logic [1:0] c_perm;

    always #2 clk = ~clk;

    l1_coh_line #(.LOCK_CYCLES(LOCK), .ACK_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_ld(ld), .core_st(st), .core_evict(ev),
        .core_dma(dm), .msg_valid(mv), .msg_kind(mk), .msg_grant(gr), .msg_acks(ac),
        .core_hit(hit), .core_stall(stall), .req_kind(rq), .rsp_ack(rack),
        .rsp_data(rdat), .line_perm(perm), .line_state(lst)
    );

    typedef struct packed {
        logic [2:0] op; logic mv; logic [2:0] mk; logic [1:0] gr; logic [3:0] ac;
        logic eh; logic es; logic [2:0] er; logic ea; logic ed;
        logic [1:0] ep; logic [3:0] ens; logic [3:0] rqn;
    } vec_t;

    // op: 0 idle, 1 load, 2 store, 3 evict, 4 dma; mkn < 0 means no message.
    function automatic vec_t V(int op, int mkn, int g, int a, int eh, int es, int er,
                               int ea, int ed, int ep, int ens, int rqn);
        vec_t v;
        v.op = 3'(op); v.mv = (mkn >= 0); v.mk = 3'((mkn < 0) ? 0 : mkn);
        v.gr = 2'(g); v.ac = 4'(a); v.eh = 1'(eh); v.es = 1'(es); v.er = 3'(er);
        v.ea = 1'(ea); v.ed = 1'(ed); v.ep = 2'(ep); v.ens = 4'(ens); v.rqn = 4'(rqn);
        return v;
    endfunction

    localparam int NV = 48;
    localparam vec_t TBL [NV] = '{
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),   // R2 load miss -> GETS
        V(1,-1,0,0, 0,1,0,0,0, 1,7, 2),   // R2 held load, no new request
        V(0, 0,0,0, 0,0,0,0,0, 1,1, 2),   // R2 shared fill -> SHR
        V(1,-1,0,0, 1,0,0,0,0, 2,1, 2),   // R2 load hit
        V(2,-1,0,0, 0,1,2,0,0, 2,9, 3),   // R3 store in SHR -> GETX, UPG
        V(1,-1,0,0, 1,0,0,0,0, 2,9, 8),   // R8 load hits in UPG
        V(3,-1,0,0, 0,1,0,0,0, 2,9, 8),   // R8 evict stalls in UPG
        V(0, 1,0,0, 0,0,0,0,0, 2,9, 7),   // R7 early ack
        V(0, 0,0,2, 0,0,0,0,0, 2,10,7),   // R7 fill count 2 -> ACKW
        V(2,-1,0,0, 0,1,0,0,0, 2,10,8),   // R8 store stalls in ACKW
        V(0, 1,0,0, 0,0,0,0,0, 2,6, 7),   // R7 last ack -> DRT_LK
        V(2,-1,0,0, 1,0,0,0,0, 3,6, 4),   // R4 store hit in DRT_LK
        V(3,-1,0,0, 0,1,0,0,0, 3,6, 5),   // R5 evict refused
        V(4,-1,0,0, 0,1,0,0,0, 3,6, 5),   // R5 dma refused
        V(0,-1,0,0, 0,0,0,0,0, 3,6, 6),   // R6 still locked
        V(0,-1,0,0, 0,0,0,0,0, 3,5, 6),   // R6 falls to DRT
        V(0, 3,0,0, 0,0,0,0,1, 3,2, 11),  // R11 fwd shared read -> OWN
        V(3,-1,0,0, 0,0,5,0,0, 2,0, 9),   // R9 PUTO with sharers
        V(0, 2,0,0, 0,0,0,1,0, 0,0, 10),  // R10 inval in INV still acks
        V(2,-1,0,0, 0,1,2,0,0, 0,8, 3),   // R3 store miss -> FILL_X
        V(0, 0,0,0, 0,0,0,0,0, 1,6, 7),   // R7 fill with zero count
        V(0, 2,0,0, 0,0,0,1,0, 3,0, 10),  // R10 inval in DRT_LK
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),   // R2
        V(0, 0,1,0, 0,0,0,0,0, 1,4, 2),   // R2 exclusive fill -> EXC_LK
        V(1,-1,0,0, 1,0,0,0,0, 2,4, 2),   // R6 window cycle 1
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(2,-1,0,0, 1,0,0,0,0, 2,6, 12),  // R12 store on expiry cycle wins
        V(1, 2,0,0, 0,1,0,1,0, 3,0, 12),  // R12 inval beats load
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),   // R2
        V(0, 0,2,0, 0,0,0,0,0, 1,2, 2),   // R2 owned fill -> OWN
        V(3,-1,0,0, 0,0,4,0,0, 2,0, 9),   // R9 plain PUTO
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),
        V(0, 0,1,0, 0,0,0,0,0, 1,4, 2),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,4, 6),
        V(0,-1,0,0, 0,0,0,0,0, 2,3, 6),   // R6 falls to EXC
        V(4,-1,0,0, 0,0,3,0,0, 2,0, 9),   // R9 dma in EXC -> PUTX
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),
        V(0, 0,0,0, 0,0,0,0,0, 1,1, 2),
        V(3,-1,0,0, 0,0,0,0,0, 2,0, 9),   // R9 silent drop from SHR
        V(3,-1,0,0, 0,0,0,0,0, 0,0, 9),   // R9 evict in INV no effect
        V(1,-1,0,0, 0,1,1,0,0, 0,7, 2),
        V(0, 0,2,0, 0,0,0,0,0, 1,2, 2),
        V(0, 4,0,0, 0,0,0,0,1, 2,0, 11)   // R11 fwd exclusive read -> INV
    };

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Drive one cycle of stimulus, capture combinational replies, let the edge pass.
    task automatic step(int op, bit m, int k, int g, int a);
        @(negedge clk);
        ld = (op == 1); st = (op == 2); ev = (op == 3); dm = (op == 4);
        mv = m; mk = 3'(k); gr = 2'(g); ac = AW'(a);
        #1;
        c_hit = hit; c_stall = stall; c_rq = rq; c_ack = rack; c_dat = rdat; c_perm = perm;
        @(posedge clk);
        #1;
        ld = 0; st = 0; ev = 0; dm = 0; mv = 0;
    endtask

    task automatic chk_state(string tag, logic [3:0] exp);
        checks++;
        if (lst !== exp) begin
            fails++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, lst, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and quiet outputs
        @(negedge clk);
        checks++;
        if (lst !== 4'd0 || perm !== 2'd0 || hit || stall || rq !== 3'd0 || rack || rdat) begin
            fails++;
            $display("FAIL R1 reset actual st=%0d perm=%0d hit=%0b stall=%0b rq=%0d expected all 0",
                     lst, perm, hit, stall, rq);
        end
        for (int i = 0; i < NV; i++) begin
            step(int'(TBL[i].op), TBL[i].mv, int'(TBL[i].mk), int'(TBL[i].gr), int'(TBL[i].ac));
            checks++;
            if (c_hit !== TBL[i].eh || c_stall !== TBL[i].es || c_rq !== TBL[i].er ||
                c_ack !== TBL[i].ea || c_dat !== TBL[i].ed || c_perm !== TBL[i].ep ||
                lst !== TBL[i].ens) begin
                fails++;
                $display("FAIL R%0d vec %0d actual h%0b s%0b rq%0d a%0b d%0b p%0d st%0d expected h%0b s%0b rq%0d a%0b d%0b p%0d st%0d",
                         TBL[i].rqn, i, c_hit, c_stall, c_rq, c_ack, c_dat, c_perm, lst,
                         TBL[i].eh, TBL[i].es, TBL[i].er, TBL[i].ea, TBL[i].ed, TBL[i].ep, TBL[i].ens);
            end
        end
        // R7 corner: all acks before the fill, then fill completes at once
        step(2, 0, 0, 0, 0);
        chk_state("R7 store miss", 4'd8);
        for (int j = 0; j < 3; j++) step(0, 1, 1, 0, 0);
        chk_state("R7 early acks wait", 4'd8);
        step(0, 1, 0, 0, 3);
        chk_state("R7 fill after acks", 4'd6);
        // R1 reset while locked returns to INV
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        chk_state("R1 reset from lock", 4'd0);
        checks++;
        if (perm !== 2'd0) begin
            fails++;
            $display("FAIL R1 perm actual=%0d expected=0", perm);
        end
        summary();
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end
endmodule